// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block takes over the processor for the few bus transfers an accepted interrupt needs. It watches a maskable request, which comes with a vector byte, and a non-maskable request. It decides whether to take either one. It then saves the return address on the stack and works out the new program counter. Last, it hands back the updated program counter, stack pointer, enable flags and halt state, marked by a one-cycle `done` strobe. Decoding and executing instructions are left to the surrounding core.

The core gives the sequencer its state in parallel: program counter, stack pointer, both enable flip-flops, the pending-after-enable flag, the halt flag, the two-bit interrupt mode and the table page register. These inputs are sampled in the cycle a request is accepted. The sequencer reaches memory over a byte bus that carries one transfer at a time. Each transfer is held until the memory answers with `mem_ready`.

The maskable modes work as follows:
- Mode value 0 maps the vector byte to one of eight restart addresses.
- Mode value 1 jumps to a fixed address.
- Mode values 2 and 3 read a 16-bit target from a table in memory.

Top module: `irq_accept_seq`

## Requirements
- R1: After reset `mem_req`, `done` and `busy` are low.
- R2: While idle, a maskable request seen with `iff1_in` low is discarded. It causes no bus transfer and no `done`, and it is not served later when `iff1_in` rises.
- R3: A non-maskable request is accepted whatever `iff1_in` is. When both requests arrive in the same cycle, the non-maskable one is served first and the maskable one is kept.
- R4: The return address is saved with two writes. The high byte goes to `sp_in-1` first, then the low byte goes to `sp_in-2`. `sp_out` equals `sp_in-2`.
- R5: When `halted_in` is high, the saved address is `pc_in+1` and `halted_out` is low.
- R6: A non-maskable interrupt gives `pc_out` = 0x0066. It clears `iff1_out` and `ei_pend_out`, and `iff2_out` keeps the sampled `iff2_in`.
- R7: A maskable interrupt clears `iff1_out`, `iff2_out` and `ei_pend_out`.
- R8: In mode values 2 and 3 the table base is `{ireg_in, vector}`. The low byte of `pc_out` is read from the base and the high byte from base+1, with a full 16-bit increment.
- R9: In mode value 1, `pc_out` is 0x0038 for any vector.
- R10: In mode value 0, `pc_out` is the vector with all bits cleared except bits 5:3, which is the restart-opcode encoding (0xDF gives 0x0018).
- R11: Each transfer keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until a cycle with `mem_ready` high.
- R12: `done` is high for exactly one cycle, the cycle after the last transfer completes. When `mem_ready` answers at once, that is 3 cycles after acceptance (5 for a table fetch).
- R13: A request that arrives while the sequencer is busy is kept and served after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Maskable request pulse |
| irq_vec | input | 8 | Vector byte sampled with `irq_req` |
| nmi_req | input | 1 | Non-maskable request pulse |
| iff1_in | input | 1 | Enable flip-flop 1 |
| iff2_in | input | 1 | Enable flip-flop 2 |
| ei_pend_in | input | 1 | Pending-after-enable flag |
| mode_in | input | 2 | Maskable mode |
| halted_in | input | 1 | Core is halted |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| ireg_in | input | 8 | Table page register |
| mem_ready | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 8 | Read data |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Transfer address |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| iff1_out | output | 1 | New enable flip-flop 1 |
| iff2_out | output | 1 | New enable flip-flop 2 |
| ei_pend_out | output | 1 | New pending-after-enable flag |
| halted_out | output | 1 | New halt state |

## Verification
Results are due at fixed times.
- A request sampled on an edge while idle raises `mem_req` on that edge.
- Each transfer lasts `waits+1` cycles under the bench's memory model.
- `done` follows the final transfer by one cycle, which gives 3+2·waits cycles, or 5+4·waits with a table fetch.

The bench drives requests on the falling edge. It then counts falling edges until `done`, compares that count with the formula, and samples every output only at that falling edge. Bus transfers are logged on the rising edge with `mem_ready` high. Their order, addresses and data are compared with the values computed from R4, R5 and R8.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_HI,
      ST_PUSH_LO,
      ST_TBL_LO,
      ST_TBL_HI
   } seq_state_t;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [DATA_W-1:0] irq_vec,
   input  logic              nmi_req,
   input  logic              iff1,
   input  logic              can_start,
   output logic              start,
   output logic              start_nmi,
   output logic [DATA_W-1:0] vec
);
   logic              nmi_p, irq_p;
   logic [DATA_W-1:0] vec_p;
   logic              nmi_any, irq_any, start_irq, drop_irq;

   assign nmi_any   = nmi_p | nmi_req;
   assign irq_any   = irq_p | irq_req;
   assign vec       = irq_req ? irq_vec : vec_p;
   assign start_nmi = can_start & nmi_any;
   assign start_irq = can_start & ~nmi_any & irq_any & iff1;
   assign drop_irq  = can_start & ~nmi_any & irq_any & ~iff1;
   assign start     = start_nmi | start_irq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_p <= 1'b0;
         irq_p <= 1'b0;
         vec_p <= '0;
      end else begin
         nmi_p <= start_nmi ? 1'b0 : nmi_any;
         irq_p <= (start_irq | drop_irq) ? 1'b0 : irq_any;
         if (irq_req) vec_p <= irq_vec;
      end
   end
endmodule

// File: rtl/irq_target_map.sv
module irq_target_map #(
   parameter int                ADDR_W          = 16,
   parameter int                DATA_W          = 8,
   parameter logic [ADDR_W-1:0] NMI_ADDR        = 16'h0066,
   parameter logic [ADDR_W-1:0] FIXED_ADDR      = 16'h0038,
   parameter bit                RST_FROM_OPCODE = 1'b1
) (
   input  logic              is_nmi,
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] vec,
   input  logic [DATA_W-1:0] ireg,
   output logic              need_table,
   output logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] table_addr
);
   logic [ADDR_W-1:0] rst_addr;

   generate
      if (RST_FROM_OPCODE) begin : g_rst_opcode
         assign rst_addr = {{(ADDR_W-6){1'b0}}, vec[5:3], 3'b000};
      end else begin : g_rst_index
         assign rst_addr = {{(ADDR_W-6){1'b0}}, vec[2:0], 3'b000};
      end
   endgenerate

   assign need_table = ~is_nmi & mode[1];
   assign table_addr = {ireg, vec};

   always_comb begin
      if (is_nmi)       target = NMI_ADDR;
      else if (mode[1]) target = '0;
      else if (mode[0]) target = FIXED_ADDR;
      else              target = rst_addr;
   end
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
   import irq_seq_pkg::*;
#(
   parameter int                ADDR_W          = 16,
   parameter int                DATA_W          = 8,
   parameter logic [ADDR_W-1:0] NMI_ADDR        = 16'h0066,
   parameter logic [ADDR_W-1:0] FIXED_ADDR      = 16'h0038,
   parameter bit                RST_FROM_OPCODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [DATA_W-1:0] irq_vec,
   input  logic              nmi_req,
   input  logic              iff1_in,
   input  logic              iff2_in,
   input  logic              ei_pend_in,
   input  logic [1:0]        mode_in,
   input  logic              halted_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [ADDR_W-1:0] sp_in,
   input  logic [DATA_W-1:0] ireg_in,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] pc_out,
   output logic [ADDR_W-1:0] sp_out,
   output logic              iff1_out,
   output logic              iff2_out,
   output logic              ei_pend_out,
   output logic              halted_out
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("ADDR_W must be twice DATA_W");
      end
      if (DATA_W < 6) begin : g_bad_data
         $error("DATA_W must hold a restart index in bits 5:3");
      end
   endgenerate

   seq_state_t        state;
   logic              can_start, start, start_nmi, need_tbl_c, xfer;
   logic [DATA_W-1:0] vec_c;
   logic [ADDR_W-1:0] tgt_c, tbl_c;
   logic [ADDR_W-1:0] pc_q, sp_q, tgt_q, tbl_q;
   logic              nmi_q, iff2_q, need_tbl_q;
   logic [DATA_W-1:0] lo_q;

   assign can_start = (state == ST_IDLE) & ~done;
   assign xfer      = mem_req & mem_ready;
   assign busy      = (state != ST_IDLE);

   irq_req_latch #(.DATA_W(DATA_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (irq_req),
      .irq_vec   (irq_vec),
      .nmi_req   (nmi_req),
      .iff1      (iff1_in),
      .can_start (can_start),
      .start     (start),
      .start_nmi (start_nmi),
      .vec       (vec_c)
   );

   irq_target_map #(
      .ADDR_W          (ADDR_W),
      .DATA_W          (DATA_W),
      .NMI_ADDR        (NMI_ADDR),
      .FIXED_ADDR      (FIXED_ADDR),
      .RST_FROM_OPCODE (RST_FROM_OPCODE)
   ) u_map (
      .is_nmi     (start_nmi),
      .mode       (mode_in),
      .vec        (vec_c),
      .ireg       (ireg_in),
      .need_table (need_tbl_c),
      .target     (tgt_c),
      .table_addr (tbl_c)
   );

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         ST_PUSH_HI: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_q - ONE;
            mem_wdata = pc_q[ADDR_W-1:DATA_W];
         end
         ST_PUSH_LO: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_q - TWO;
            mem_wdata = pc_q[DATA_W-1:0];
         end
         ST_TBL_LO: begin
            mem_req  = 1'b1;
            mem_addr = tbl_q;
         end
         ST_TBL_HI: begin
            mem_req  = 1'b1;
            mem_addr = tbl_q + ONE;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         pc_q        <= '0;
         sp_q        <= '0;
         tgt_q       <= '0;
         tbl_q       <= '0;
         nmi_q       <= 1'b0;
         iff2_q      <= 1'b0;
         need_tbl_q  <= 1'b0;
         lo_q        <= '0;
         done        <= 1'b0;
         pc_out      <= '0;
         sp_out      <= '0;
         iff1_out    <= 1'b0;
         iff2_out    <= 1'b0;
         ei_pend_out <= 1'b0;
         halted_out  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  pc_q       <= halted_in ? pc_in + ONE : pc_in;
                  sp_q       <= sp_in;
                  tgt_q      <= tgt_c;
                  tbl_q      <= tbl_c;
                  nmi_q      <= start_nmi;
                  iff2_q     <= iff2_in;
                  need_tbl_q <= need_tbl_c;
                  state      <= ST_PUSH_HI;
               end
            end
            ST_PUSH_HI: if (xfer) state <= ST_PUSH_LO;
            ST_PUSH_LO: begin
               if (xfer) begin
                  if (need_tbl_q) begin
                     state <= ST_TBL_LO;
                  end else begin
                     state  <= ST_IDLE;
                     pc_out <= tgt_q;
                     done   <= 1'b1;
                  end
               end
            end
            ST_TBL_LO: begin
               if (xfer) begin
                  lo_q  <= mem_rdata;
                  state <= ST_TBL_HI;
               end
            end
            ST_TBL_HI: begin
               if (xfer) begin
                  pc_out <= {mem_rdata, lo_q};
                  state  <= ST_IDLE;
                  done   <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
         if ((state == ST_TBL_HI && xfer) ||
             (state == ST_PUSH_LO && xfer && !need_tbl_q)) begin
            sp_out      <= sp_q - TWO;
            iff1_out    <= 1'b0;
            iff2_out    <= nmi_q & iff2_q;
            ei_pend_out <= 1'b0;
            halted_out  <= 1'b0;
         end
      end
   end
   // ei_pend_in is accepted for interface completeness; every accept clears it.
   logic unused_ok;
   assign unused_ok = ei_pend_in;
endmodule

// File: rtl/irq_seq_checker.sv
module irq_seq_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_ready,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              busy,
   input logic              done,
   input logic              iff1_out,
   input logic              ei_pend_out,
   input logic              halted_out
);
   a_r11_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r12_done_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req && !busy);

   // R6 and R7: every accepted interrupt leaves flip-flop 1, pending flag and halt cleared
   a_r7_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !iff1_out && !ei_pend_out && !halted_out);

   a_r4_push_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> mem_we);

   a_r1_idle_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
endmodule

bind irq_accept_seq irq_seq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_irq_seq_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_ready   (mem_ready),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .busy        (busy),
   .done        (done),
   .iff1_out    (iff1_out),
   .ei_pend_out (ei_pend_out),
   .halted_out  (halted_out)
);

// File: tb/test_irq_accept_seq.sv
module test_irq_accept_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0, nmi_req = 1'b0;
   logic [7:0]  irq_vec = '0;
   logic        iff1_in = 1'b0, iff2_in = 1'b0, ei_pend_in = 1'b0, halted_in = 1'b0;
   logic [1:0]  mode_in = 2'd0;
   logic [15:0] pc_in = '0, sp_in = '0;
   logic [7:0]  ireg_in = '0;
   logic        mem_ready;
   logic [7:0]  mem_rdata;
   logic        mem_req, mem_we, busy, done;
   logic [15:0] mem_addr, pc_out, sp_out;
   logic [7:0]  mem_wdata;
   logic        iff1_out, iff2_out, ei_pend_out, halted_out;

   int checks = 0;
   int errors = 0;
   int waits_cfg = 0;
   int wcnt = 0;
   int log_n = 0;
   logic [15:0] log_addr [64];
   logic [7:0]  log_data [64];
   logic        log_we   [64];

   always #5 clk = ~clk;

   irq_accept_seq i_irq_accept_seq (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec), .nmi_req(nmi_req),
      .iff1_in(iff1_in), .iff2_in(iff2_in), .ei_pend_in(ei_pend_in), .mode_in(mode_in),
      .halted_in(halted_in), .pc_in(pc_in), .sp_in(sp_in), .ireg_in(ireg_in),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
      .pc_out(pc_out), .sp_out(sp_out), .iff1_out(iff1_out), .iff2_out(iff2_out),
      .ei_pend_out(ei_pend_out), .halted_out(halted_out)
   );

   function automatic logic [7:0] mem_fn(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   assign mem_rdata = mem_fn(mem_addr);
   assign mem_ready = mem_req && (wcnt >= waits_cfg);

   always @(posedge clk) begin
      if (!mem_req || mem_ready) wcnt <= 0;
      else wcnt <= wcnt + 1;
      if (mem_req && mem_ready) begin
         log_addr[log_n % 64] <= mem_addr;
         log_we[log_n % 64]   <= mem_we;
         log_data[log_n % 64] <= mem_we ? mem_wdata : mem_rdata;
         log_n <= log_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         irq_req = 1'b0;
         nmi_req = 1'b0;
         cyc++;
      end while (!done && cyc < 300);
   endtask

   task automatic fire(input bit nmi, input bit irq, input logic [7:0] vec);
      @(negedge clk);
      nmi_req = nmi;
      irq_req = irq;
      irq_vec = vec;
   endtask

   task automatic check_log(input int idx, input bit we, input logic [15:0] a,
                            input logic [7:0] d, input string req);
      check(log_we[idx % 64] == we, req, 16'(log_we[idx % 64]), 16'(we));
      check(log_addr[idx % 64] == a, req, log_addr[idx % 64], a);
      check(log_data[idx % 64] == d, req, 16'(log_data[idx % 64]), 16'(d));
   endtask

   task automatic t_reset();
      check(!mem_req, "R1", 16'(mem_req), 16'h0);
      check(!done, "R1", 16'(done), 16'h0);
      check(!busy, "R1", 16'(busy), 16'h0);
   endtask

   task automatic t_nmi_basic();
      int cyc, base;
      waits_cfg = 0; pc_in = 16'h1234; sp_in = 16'hF000;
      iff1_in = 1; iff2_in = 1; ei_pend_in = 1; halted_in = 0; mode_in = 2'd1;
      base = log_n;
      fire(1, 0, 8'h00);
      wait_done(cyc);
      check(cyc == 3, "R12", 16'(cyc), 16'd3);
      check_log(base, 1, 16'hEFFF, 8'h12, "R4");
      check_log(base + 1, 1, 16'hEFFE, 8'h34, "R4");
      check(sp_out == 16'hEFFE, "R4", sp_out, 16'hEFFE);
      check(pc_out == 16'h0066, "R6", pc_out, 16'h0066);
      check(!iff1_out && iff2_out && !ei_pend_out, "R6",
            {13'd0, iff1_out, iff2_out, ei_pend_out}, 16'h2);
      @(negedge clk);
      check(!done, "R12", 16'(done), 16'h0);
   endtask

   task automatic t_nmi_halt();
      int cyc, base;
      pc_in = 16'h00FF; sp_in = 16'h8000; iff1_in = 0; iff2_in = 0; halted_in = 1;
      base = log_n;
      fire(1, 0, 8'h00);
      wait_done(cyc);
      check(done, "R3", 16'(done), 16'h1);
      check_log(base, 1, 16'h7FFF, 8'h01, "R5");
      check_log(base + 1, 1, 16'h7FFE, 8'h00, "R5");
      check(!halted_out, "R5", 16'(halted_out), 16'h0);
      check(!iff2_out, "R6", 16'(iff2_out), 16'h0);
      halted_in = 0;
   endtask

   task automatic t_mode1();
      int cyc;
      pc_in = 16'h4321; sp_in = 16'h2000; iff1_in = 1; iff2_in = 1; ei_pend_in = 1;
      mode_in = 2'd1;
      fire(0, 1, 8'hAB);
      wait_done(cyc);
      check(pc_out == 16'h0038, "R9", pc_out, 16'h0038);
      check(!iff1_out && !iff2_out && !ei_pend_out, "R7",
            {13'd0, iff1_out, iff2_out, ei_pend_out}, 16'h0);
      check(cyc == 3, "R12", 16'(cyc), 16'd3);
   endtask

   task automatic t_mode0(input logic [7:0] vec, input logic [15:0] exp);
      int cyc;
      iff1_in = 1; mode_in = 2'd0;
      fire(0, 1, vec);
      wait_done(cyc);
      check(pc_out == exp, "R10", pc_out, exp);
   endtask

   task automatic t_table(input logic [1:0] md, input logic [7:0] pg, input logic [7:0] vec,
                          input int w);
      int cyc, base;
      logic [15:0] ta;
      ta = {pg, vec};
      waits_cfg = w; iff1_in = 1; mode_in = md; ireg_in = pg; sp_in = 16'h3000;
      pc_in = 16'hBEEF;
      base = log_n;
      fire(0, 1, vec);
      wait_done(cyc);
      check(cyc == 5 + 4 * w, "R11", 16'(cyc), 16'(5 + 4 * w));
      check_log(base + 2, 0, ta, mem_fn(ta), "R8");
      check_log(base + 3, 0, ta + 16'd1, mem_fn(ta + 16'd1), "R8");
      check(pc_out == {mem_fn(ta + 16'd1), mem_fn(ta)}, "R8", pc_out,
            {mem_fn(ta + 16'd1), mem_fn(ta)});
      waits_cfg = 0;
   endtask

   task automatic t_wait_push();
      int cyc;
      waits_cfg = 3; iff1_in = 1; mode_in = 2'd1;
      fire(0, 1, 8'h00);
      wait_done(cyc);
      check(cyc == 9, "R11", 16'(cyc), 16'd9);
      waits_cfg = 0;
   endtask

   task automatic t_masked();
      int seen;
      seen = 0;
      iff1_in = 0; mode_in = 2'd1;
      fire(0, 1, 8'h10);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         irq_req = 0;
         if (mem_req || done) seen++;
      end
      check(seen == 0, "R2", 16'(seen), 16'h0);
      iff1_in = 1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (mem_req || done) seen++;
      end
      check(seen == 0, "R2", 16'(seen), 16'h0);
   endtask

   task automatic t_priority();
      int cyc;
      iff1_in = 1; mode_in = 2'd1;
      fire(1, 1, 8'h00);
      wait_done(cyc);
      check(pc_out == 16'h0066, "R3", pc_out, 16'h0066);
      wait_done(cyc);
      check(done && pc_out == 16'h0038, "R3", pc_out, 16'h0038);
   endtask

   task automatic t_held();
      int cyc;
      iff1_in = 1; mode_in = 2'd0;
      fire(1, 0, 8'h00);
      @(negedge clk);
      nmi_req = 0;
      irq_req = 1; irq_vec = 8'hEF;
      wait_done(cyc);
      check(pc_out == 16'h0066, "R13", pc_out, 16'h0066);
      wait_done(cyc);
      check(done && pc_out == 16'h0028, "R13", pc_out, 16'h0028);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_nmi_basic();
      t_nmi_halt();
      t_mode1();
      t_mode0(8'hDF, 16'h0018);
      t_mode0(8'hC7, 16'h0000);
      t_mode0(8'hFF, 16'h0038);
      t_table(2'd2, 8'h40, 8'h10, 2);
      t_table(2'd2, 8'h12, 8'hFF, 0);
      t_table(2'd3, 8'h7E, 8'h22, 1);
      t_wait_push();
      t_masked();
      t_priority();
      t_held();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule